// File: doc/BRIEF.md
# Per-Slot Priority Bus Grant Arbiter

This block sits between a set of expansion slots and one processor that uses an active-low bus request and bus grant handshake. Every slot drives a request line of its own and receives a grant line of its own. The arbiter merges all slot requests into the single processor bus request. When the processor answers with its grant, the arbiter chooses one slot by fixed priority and holds that choice. It passes the grant to that slot only.

The choice stays fixed until the owning slot has finished with the bus. The slot must have withdrawn its request and negated the acknowledge line, and the processor must have taken back its grant. After that release the arbiter holds off every new winner selection. The holdoff lasts until the processor grant has been seen inactive for at least one whole clock. Every slot and processor input passes through a two-flop synchronizer, and the per-slot grant outputs come from registers. The chosen slot index and an ownership flag are brought out for observation.

Top module: `slot_grant_arbiter`

## Requirements
- R1: Each slot has a dedicated active-low grant output. At no time are two or more grant outputs low together.
- R2: When several slots are requesting at the moment the processor grant is first seen, the slot with the lowest index wins. Slot 0 has the highest priority.
- R3: While a slot owns the bus, new requests from any slot do not change `winnerIdx` and do not move the grant. This includes requests from higher-priority slots.
- R4: After an ownership period ends, no slot is selected while the synchronized processor grant stays asserted. Selection resumes only after the grant has been negated for at least one clock.
- R5: `cpuBrN` is low while at least one synchronized slot request is low, and high otherwise. An input change reaches `cpuBrN` within three clocks.
- R6: A slot grant is low only while its slot owns the bus and the processor grant is asserted. Negating the processor grant raises all slot grants.
- R7: Ownership ends only when three conditions hold together: the winner's request is high, `bgackN` is high, and the processor grant is negated. `busy` then falls.
- R8: After reset, all slot grants are high, `cpuBrN` is high, `busy` is low and `winnerIdx` is 0.
- R9: `busy` is high exactly while a slot is latched as owner. While `busy` is high, `winnerIdx` gives that slot's index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slotReqN | input | SLOTS | Per-slot bus request, active low |
| cpuBgN | input | 1 | Processor bus grant, active low |
| bgackN | input | 1 | Bus owner acknowledge, active low |
| cpuBrN | output | 1 | Combined bus request to processor, active low |
| slotGntN | output | SLOTS | Per-slot bus grant, registered, active low |
| winnerIdx | output | $clog2(SLOTS) | Index of the latched owner |
| busy | output | 1 | A slot is latched as owner |

## Verification
The bench goes after several corner cases.

- Priority between simultaneous requests. Random request masks are applied before the processor grant. An encoder with the wrong direction, or with an off-by-one error, hands the bus to the wrong slot.
- Late higher-priority requests. These arrive during ownership. A design without the latch would move the grant in mid-transfer.
- A processor grant that is negated for a single clock and then reasserted. This exposes a missing holdoff: the next waiting slot would be granted at once.
- Each release condition on its own. The bench withholds one condition at a time, so a design that releases early drops `busy` while the acknowledge is still asserted.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // load a new winner this cycle
    logic owned;    // a winner is latched
    logic grantEn;  // drive the latched winner's grant
  } arbCtl_t;

endpackage

// File: rtl/slot_arb_sync.sv
module slot_arb_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] IDLE = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= IDLE;
      syncOut <= IDLE;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end

endmodule

// File: rtl/slot_arb_ctrl.sv
module slot_arb_ctrl
  import slot_arb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    anyReq,
  input  logic    winnerReq,
  input  logic    bgActive,
  input  logic    bgackActive,
  output arbCtl_t ctl
);

  logic owned;
  logic holdoff;
  logic doCapture;
  logic doRelease;

  assign doCapture = !owned && !holdoff && bgActive && anyReq;
  assign doRelease = owned && !winnerReq && !bgackActive && !bgActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owned   <= 1'b0;
      holdoff <= 1'b0;
    end else begin
      if (doCapture) begin
        owned <= 1'b1;
      end else if (doRelease) begin
        owned <= 1'b0;
      end

      if (doRelease) begin
        holdoff <= 1'b1;
      end else if (holdoff && !bgActive) begin
        holdoff <= 1'b0;
      end
    end
  end

  assign ctl.capture = doCapture;
  assign ctl.owned   = owned;
  assign ctl.grantEn = owned && bgActive;

  AST_HOLDOFF_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (holdoff && bgActive) |=> !owned); // R4

endmodule

// File: rtl/slot_arb_datapath.sv
module slot_arb_datapath
  import slot_arb_pkg::*;
#(
  parameter int SLOTS = 5,
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SLOTS-1:0] reqActive,
  input  arbCtl_t          ctl,
  output logic             anyReq,
  output logic             winnerReq,
  output logic [IW-1:0]    winner,
  output logic [SLOTS-1:0] gntN
);

  logic [IW-1:0] pickIdx;

  // Fixed priority: lowest index wins
  always_comb begin
    pickIdx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (reqActive[i]) pickIdx = IW'(i);
    end
  end

  assign anyReq    = |reqActive;
  assign winnerReq = reqActive[winner];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winner <= '0;
    end else if (ctl.capture) begin
      winner <= pickIdx;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : gGrant
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gntN[g] <= 1'b1;
      end else begin
        gntN[g] <= !(ctl.grantEn && (winner == IW'(g)));
      end
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~gntN)); // R1

  AST_WINNER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.owned |=> (!ctl.owned || $stable(winner))); // R3

endmodule

// File: rtl/slot_grant_arbiter.sv
module slot_grant_arbiter
  import slot_arb_pkg::*;
#(
  parameter int SLOTS = 5,
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SLOTS-1:0] slotReqN,
  input  logic             cpuBgN,
  input  logic             bgackN,
  output logic             cpuBrN,
  output logic [SLOTS-1:0] slotGntN,
  output logic [IW-1:0]    winnerIdx,
  output logic             busy
);

  logic [SLOTS-1:0] reqSyncN;
  logic [1:0]       cpuSyncN;
  logic             anyReq;
  logic             winnerReq;
  arbCtl_t          ctl;

  slot_arb_sync #(.WIDTH(SLOTS), .IDLE({SLOTS{1'b1}})) uReqSync (
    .clk(clk), .rstN(rstN), .asyncIn(slotReqN), .syncOut(reqSyncN)
  );

  slot_arb_sync #(.WIDTH(2), .IDLE(2'b11)) uCpuSync (
    .clk(clk), .rstN(rstN), .asyncIn({cpuBgN, bgackN}), .syncOut(cpuSyncN)
  );

  slot_arb_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .anyReq(anyReq), .winnerReq(winnerReq),
    .bgActive(!cpuSyncN[1]), .bgackActive(!cpuSyncN[0]),
    .ctl(ctl)
  );

  slot_arb_datapath #(.SLOTS(SLOTS)) uDp (
    .clk(clk), .rstN(rstN),
    .reqActive(~reqSyncN), .ctl(ctl),
    .anyReq(anyReq), .winnerReq(winnerReq),
    .winner(winnerIdx), .gntN(slotGntN)
  );

  assign cpuBrN = !anyReq;
  assign busy   = ctl.owned;

  AST_GNT_NEEDS_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    (slotGntN != '1) |-> busy); // R6

endmodule

// File: tb/slot_grant_arbiter_test.sv
`timescale 1ns/1ps
module slot_grant_arbiter_test;

  localparam int SLOTS = 5;
  localparam int IW = $clog2(SLOTS);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [SLOTS-1:0] slotReqN = '1;
  logic             cpuBgN = 1'b1;
  logic             bgackN = 1'b1;
  logic             cpuBrN;
  logic [SLOTS-1:0] slotGntN;
  logic [IW-1:0]    winnerIdx;
  logic             busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  slot_grant_arbiter #(.SLOTS(SLOTS)) uut (
    .clk(clk), .rstN(rstN), .slotReqN(slotReqN), .cpuBgN(cpuBgN),
    .bgackN(bgackN), .cpuBrN(cpuBrN), .slotGntN(slotGntN),
    .winnerIdx(winnerIdx), .busy(busy)
  );

  function automatic int expWinner(logic [SLOTS-1:0] mask);
    for (int i = 0; i < SLOTS; i++) if (mask[i]) return i;
    return 0;
  endfunction

  function automatic logic [SLOTS-1:0] expGnt(int idx);
    return ~(SLOTS'(1) << idx);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic randomRound();
    logic [SLOTS-1:0] p;
    logic [SLOTS-1:0] q;
    int w;
    p = SLOTS'($urandom_range(1, (1 << SLOTS) - 1));
    w = expWinner(p);
    slotReqN = ~p;
    waitN(4);
    chk("R5 request merged", 32'(cpuBrN), 32'd0);
    cpuBgN = 1'b0;
    waitN(5);
    chk("R2 priority winner", 32'(winnerIdx), 32'(w));
    chk("R1 single grant", 32'(slotGntN), 32'(expGnt(w)));
    chk("R9 busy owned", 32'(busy), 32'd1);
    q = p | SLOTS'($urandom);
    slotReqN = ~q;
    waitN(5);
    chk("R3 winner held", 32'(winnerIdx), 32'(w));
    chk("R3 grant held", 32'(slotGntN), 32'(expGnt(w)));
    bgackN = 1'b0;
    q[w] = 1'b0;
    slotReqN = ~q;
    waitN(5);
    chk("R7 held with bg active", 32'(busy), 32'd1);
    cpuBgN = 1'b1;
    waitN(5);
    chk("R6 grants drop", 32'(slotGntN), 32'(SLOTS'('1)));
    chk("R7 held with bgack", 32'(busy), 32'd1);
    bgackN = 1'b1;
    waitN(5);
    chk("R7 released", 32'(busy), 32'd0);
    slotReqN = '1;
    waitN(5);
    chk("R5 request idle", 32'(cpuBrN), 32'd1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    waitN(3);
    chk("R8 grants", 32'(slotGntN), 32'(SLOTS'('1)));
    chk("R8 br", 32'(cpuBrN), 32'd1);
    chk("R8 busy", 32'(busy), 32'd0);
    chk("R8 winner", 32'(winnerIdx), 32'd0);
    rstN = 1'b1;
    waitN(3);

    // Directed: all slots together, then only the lowest priority slot
    slotReqN = '0;
    waitN(4);
    cpuBgN = 1'b0;
    waitN(5);
    chk("R2 all request", 32'(winnerIdx), 32'd0);
    cpuBgN = 1'b1;
    slotReqN = '1;
    waitN(6);
    chk("R7 release all", 32'(busy), 32'd0);

    slotReqN = ~(SLOTS'(1) << (SLOTS - 1));
    waitN(4);
    cpuBgN = 1'b0;
    waitN(5);
    chk("R2 lowest slot", 32'(winnerIdx), 32'(SLOTS - 1));
    chk("R1 lowest slot grant", 32'(slotGntN), 32'(expGnt(SLOTS - 1)));

    // R4 holdoff: slot 1 waiting, owner done, bg negated for one clock only
    slotReqN = ~(SLOTS'(2));
    waitN(6);
    chk("R3 later higher request", 32'(winnerIdx), 32'(SLOTS - 1));
    cpuBgN = 1'b1;
    waitN(1);
    cpuBgN = 1'b0;
    waitN(8);
    chk("R4 holdoff busy", 32'(busy), 32'd0);
    chk("R4 holdoff grants", 32'(slotGntN), 32'(SLOTS'('1)));
    cpuBgN = 1'b1;
    waitN(1);
    cpuBgN = 1'b0;
    waitN(6);
    chk("R4 resumes", 32'(winnerIdx), 32'd1);
    chk("R4 resumed grant", 32'(slotGntN), 32'(expGnt(1)));
    cpuBgN = 1'b1;
    slotReqN = '1;
    waitN(6);
    chk("R7 release after holdoff", 32'(busy), 32'd0);

    for (int r = 0; r < 25; r++) randomRound();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule